// File: doc/BRIEF.md
# Clock Alarm Transition Event Register

This block sits beside a telecom clock synchroniser and watches four alarm levels from it: primary reference lost, secondary reference lost, PLL holdover and PLL unlock. Each level is first brought into the local clock domain through a short flop chain. The block then compares it with its value one cycle earlier. A rising or a falling transition sets its own sticky bit in an 8-bit event register. A level interrupt stays asserted while any event bit is set.

Software reaches the block through a byte-wide register read port with a 3-bit offset. Offset 2 returns a live, synchronised view of the four alarms together with four unrelated auxiliary bits. Offset 6 returns the event register and clears it in the same access. Offset 7 identifies the interrupt line. Before enabling the interrupt, a driver does one read of offset 6 to discard stale events. A transition that lands in the same cycle as a clearing read is kept for the next read.

Top module: `clkmon_event_reg`

## Requirements
- R1: While reset is high, and on the first cycle after it, `evt_irq_o` is 0, `rd_data_o` is 0x00 and the event register holds 0x00.
- R2: Event bit positions are fixed by input and direction. Primary-lost uses bit 0 for 0→1 and bit 1 for 1→0. Secondary-lost uses bit 2 (0→1) and bit 3 (1→0). Holdover uses bit 4 (0→1) and bit 5 (1→0). Unlock uses bit 6 (0→1) and bit 7 (1→0).
- R3: Event bits are sticky. A set bit stays set until a clearing read, and events from different transitions accumulate.
- R4: A read with `rd_en_i`=1 and `rd_addr_i`=6 puts the event register on `rd_data_o` at the next clock edge and clears every bit at that same edge.
- R5: A transition detected in the same cycle as a clearing read is not part of that read's data. It is set in the register after the clear, so the next read returns it.
- R6: `evt_irq_o` goes to 1 at the same edge at which an event bit becomes set. It falls at the edge of a clearing read, unless a transition is detected in that cycle.
- R7: A read of offset 2 returns primary-lost in bit 7, secondary-lost in bit 6, holdover in bit 5 and unlock in bit 4, all taken after synchronisation. Bits 3:0 return `aux_stat_i` as sampled on the read edge.
- R8: A read of offset 7 returns 0 in bits 7:4 and the parameter `IRQ_LINE` in bits 3:0. A value of 0xF there would mean the function is absent. Offsets other than 2, 6 and 7 read 0x00. No read of any offset other than 6 changes the event register.
- R9: An alarm input change made between two clock edges appears in the event register, and on `evt_irq_o`, at the third rising edge after the change.
- R10: Alarm inputs that are held at 1 through reset create no event after reset is released.
- R11: `rd_data_o` keeps its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| los_pri_i | input | 1 | Primary reference lost, asynchronous level |
| los_sec_i | input | 1 | Secondary reference lost, asynchronous level |
| holdover_i | input | 1 | PLL in holdover, asynchronous level |
| unlock_i | input | 1 | PLL unlocked, asynchronous level |
| aux_stat_i | input | 4 | Auxiliary bits returned in the low nibble of the status byte |
| rd_en_i | input | 1 | Read strobe, one access per cycle |
| rd_addr_i | input | 3 | Register offset |
| rd_data_o | output | 8 | Registered read data |
| evt_irq_o | output | 1 | Level interrupt, set while any event is pending |

## Verification
Stored events are visible at the ports only through a clearing read and the interrupt level. A lost, extra or misplaced event bit therefore appears either as a wrong `evt_irq_o` level at the edge where the event should have latched, or as a wrong byte on the next offset-6 read. A wrong edge history shows up as an event on the wrong bit, or as a false event after reset. A clear that swallows a concurrent transition leaves the next read empty where it should be non-zero. The bench drives transitions on exact cycles, including one placed in the cycle of a clearing read. It compares the interrupt and the read data against its own model on every clock.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int N_ALARM  = 4;
  localparam int N_EVT    = 2 * N_ALARM;
  localparam int AUX_W    = DATA_W - N_ALARM;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_EVENT  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_LINEID = 3'd7;

  // alarm index order sets the event bit pairs: 2*i rise, 2*i+1 fall
  typedef enum int {
    ALM_PRI  = 0,
    ALM_SEC  = 1,
    ALM_HOLD = 2,
    ALM_UNLK = 3
  } alarm_idx_e;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  // no reset: chain keeps tracking the inputs while rst is high
  always_ff @(posedge clk) chain[0] <= async_i;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/clkmon_edge.sv
module clkmon_edge #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   lvl_i,
  output logic [2*WIDTH-1:0] edge_o
);
  logic [WIDTH-1:0] hist_q;

  // history follows the level during reset so release yields no edge
  always_ff @(posedge clk) hist_q <= lvl_i;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_dir
      assign edge_o[2*i]   =  lvl_i[i] & ~hist_q[i];
      assign edge_o[2*i+1] = ~lvl_i[i] &  hist_q[i];
    end
  endgenerate

  logic unused_rst;
  assign unused_rst = rst;
endmodule

// File: rtl/clkmon_evreg.sv
module clkmon_evreg #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] edge_i,
  input  logic             clr_i,
  output logic [N_EVT-1:0] evt_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] evt_q;
  logic [N_EVT-1:0] evt_d;
  logic             irq_q;

  always_comb begin
    evt_d = (clr_i ? '0 : evt_q) | edge_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      irq_q <= |evt_d;
    end
  end

  assign evt_o = evt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/clkmon_event_reg.sv
module clkmon_event_reg
  import clkmon_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  IRQ_LINE    = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              los_pri_i,
  input  logic              los_sec_i,
  input  logic              holdover_i,
  input  logic              unlock_i,
  input  logic [AUX_W-1:0]  aux_stat_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              evt_irq_o
);
  logic [N_ALARM-1:0] alm_raw;
  logic [N_ALARM-1:0] alm_sync;
  logic [N_EVT-1:0]   edge_w;
  logic [N_EVT-1:0]   evt_q;
  logic               clr_w;
  logic [DATA_W-1:0]  status_w;
  logic [DATA_W-1:0] rd_q;

  assign alm_raw[ALM_PRI]  = los_pri_i;
  assign alm_raw[ALM_SEC]  = los_sec_i;
  assign alm_raw[ALM_HOLD] = holdover_i;
  assign alm_raw[ALM_UNLK] = unlock_i;

  clkmon_sync #(.WIDTH(N_ALARM), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .async_i (alm_raw),
    .sync_o  (alm_sync)
  );

  clkmon_edge #(.WIDTH(N_ALARM)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (alm_sync),
    .edge_o (edge_w)
  );

  assign clr_w = rd_en_i && (rd_addr_i == OFS_EVENT);

  clkmon_evreg #(.N_EVT(N_EVT)) u_evreg (
    .clk    (clk),
    .rst    (rst),
    .edge_i (edge_w),
    .clr_i  (clr_w),
    .evt_o  (evt_q),
    .irq_o  (evt_irq_o)
  );

  // status byte: alarms in the high nibble, reversed index order
  generate
    for (genvar i = 0; i < N_ALARM; i++) begin : g_stat
      assign status_w[DATA_W-1-i] = alm_sync[i];
    end
  endgenerate
  assign status_w[AUX_W-1:0] = aux_stat_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      case (rd_addr_i)
        OFS_STATUS: rd_q <= status_w;
        OFS_EVENT:  rd_q <= evt_q;
        OFS_LINEID: rd_q <= {{(DATA_W-4){1'b0}}, IRQ_LINE};
        default:    rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/clkmon_event_reg_chk.sv
module clkmon_event_reg_chk #(
  parameter logic [3:0] IRQ_LINE = 4'h5
) (
  input logic       clk,
  input logic       rst,
  input logic       rd_en_i,
  input logic [2:0] rd_addr_i,
  input logic [3:0] aux_stat_i,
  input logic [7:0] rd_data_o,
  input logic [7:0] evt_q,
  input logic       evt_irq_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (evt_q == 8'h00) && !evt_irq_o && (rd_data_o == 8'h00));

  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_q != 8'h00) == evt_irq_o);

  // R4
  clear_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i == 3'd6) |=> rd_data_o == $past(evt_q));

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en_i && rd_addr_i == 3'd6) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R8
  line_id_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i == 3'd7) |=> rd_data_o == {4'h0, IRQ_LINE});

  // R7
  aux_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i == 3'd2) |=> rd_data_o[3:0] == $past(aux_stat_i));

  // R11
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind clkmon_event_reg clkmon_event_reg_chk #(.IRQ_LINE(IRQ_LINE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .aux_stat_i (aux_stat_i),
  .rd_data_o  (rd_data_o),
  .evt_q      (evt_q),
  .evt_irq_o  (evt_irq_o)
);

// File: tb/clkmon_event_reg_bench.sv
`timescale 1ns/1ps
module clkmon_event_reg_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pri = 1'b0, sec = 1'b0, hold = 1'b0, unlk = 1'b0;
  logic [3:0] aux = 4'h0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clkmon_event_reg #(.SYNC_STAGES(2), .IRQ_LINE(4'h5)) u_clkmon_event_reg (
    .clk(clk), .rst(rst), .los_pri_i(pri), .los_sec_i(sec),
    .holdover_i(hold), .unlock_i(unlk), .aux_stat_i(aux),
    .rd_en_i(rd_en), .rd_addr_i(addr), .rd_data_o(rdata), .evt_irq_o(irq)
  );

  // behavioural reference: delay line of sampled alarm levels
  int lvl_q[$];
  int m_prev = 0;
  int m_evt = 0;
  int m_irq = 0;
  int m_rd = 0;

  always @(posedge clk) begin
    int cur, s2, edges, rising, falling, nrd;
    cur = {pri, sec, hold, unlk};     // bit3 pri .. bit0 unlk
    lvl_q.push_back(cur);
    s2 = (lvl_q.size() > 2) ? lvl_q[lvl_q.size()-3] : 0;
    if (lvl_q.size() > 3) void'(lvl_q.pop_front());
    rising = s2 & ~m_prev; falling = ~s2 & m_prev;
    edges = 0;
    for (int i = 0; i < 4; i++) begin
      // alarm i counted from pri: value bit (3-i)
      if (rising[3-i])  edges |= (1 << (2*i));
      if (falling[3-i]) edges |= (1 << (2*i+1));
    end
    if (rst) begin
      m_evt = 0; m_irq = 0; m_rd = 0;
    end else begin
      nrd = m_rd;
      if (rd_en) begin
        case (addr)
          3'd2: nrd = ((s2 & 15) << 4) | aux;
          3'd6: nrd = m_evt;
          3'd7: nrd = 5;
          default: nrd = 0;
        endcase
      end
      m_evt = ((rd_en && addr == 3'd6) ? 0 : m_evt) | edges;
      m_irq = (m_evt != 0);
      m_rd = nrd;
    end
    m_prev = s2;
  end

  always @(negedge clk) begin
    if (!rst && cycles > 4) begin
      checks++;
      if (irq !== m_irq[0]) begin
        errors++;
        $display("FAIL R6 model irq: actual %0b expected %0d", irq, m_irq);
      end
      checks++;
      if (rdata !== m_rd[7:0]) begin
        errors++;
        $display("FAIL R2/R4 model rdata: actual %02h expected %02h", rdata, m_rd[7:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  logic [7:0] d;

  initial begin
    // R10: alarms held high through reset
    pri = 1'b1; unlk = 1'b1;
    wait_cyc(6);
    chk("R1 irq in reset", irq, 0);
    chk("R1 rdata in reset", rdata, 0);
    @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", irq, 0);
    wait_cyc(5);
    chk("R10 no false irq", irq, 0);
    rd(3'd6, d); chk("R10 no false event", d, 8'h00);

    // R9: change at negedge, latch on third rising edge
    @(negedge clk); pri = 1'b0;
    wait_cyc(2); chk("R9 not yet after two edges", irq, 0);
    wait_cyc(1); chk("R9 irq at third edge", irq, 1);
    rd(3'd6, d); chk("R2 pri fall bit1", d, 8'h02);
    chk("R6 irq low after clear", irq, 0);

    // R2/R3 accumulate
    @(negedge clk); pri = 1'b1; sec = 1'b1;
    wait_cyc(4);
    @(negedge clk); sec = 1'b0; hold = 1'b1;
    wait_cyc(4);
    @(negedge clk); hold = 1'b0; unlk = 1'b0;
    wait_cyc(4);
    rd(3'd6, d); chk("R2/R3 accumulated", d, 8'hBD);
    rd(3'd6, d); chk("R4 cleared", d, 8'h00);

    // R7 status byte
    aux = 4'hA;
    rd(3'd2, d); chk("R7 status", d, 8'h8A);
    // R8 id and other offsets, events untouched
    @(negedge clk); unlk = 1'b1;
    wait_cyc(4);
    rd(3'd7, d); chk("R8 line id", d, 8'h05);
    rd(3'd0, d); chk("R8 unused offset", d, 8'h00);
    rd(3'd2, d); chk("R7 status unlock", d, 8'h9A);
    wait_cyc(3);
    chk("R11 hold data", rdata, 8'h9A);
    rd(3'd6, d); chk("R8 event kept after other reads", d, 8'h40);

    // R5: edge in the clearing-read cycle
    @(negedge clk); hold = 1'b1;
    wait_cyc(4);
    @(negedge clk); unlk = 1'b0;
    @(negedge clk);
    @(negedge clk); rd_en = 1'b1; addr = 3'd6;
    @(negedge clk); rd_en = 1'b0;
    chk("R5 read excludes same-cycle edge", rdata, 8'h10);
    chk("R6 irq held by new edge", irq, 1);
    rd(3'd6, d); chk("R5 same-cycle edge kept", d, 8'h80);
    chk("R6 irq falls", irq, 0);

    wait_cyc(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule